// File: doc/BRIEF.md
# Compressed Load/Store Address Unit

This unit serves the memory instructions of a 16-bit compressed instruction encoding. For each access it takes the operand values and a short offset field from the decoder. It forms the effective address from one of three bases: a general register, the stack pointer, or the program counter. It then issues a single request on a simple valid/ready memory port. When the data comes back, it sign-extends or zero-extends it to the register width and signals completion with a one-cycle `done` pulse.

The offset field is always unsigned and is multiplied by the access size. In the word forms relative to the stack pointer or the program counter, the field is 8 bits wide. In all other forms it is 5 bits wide. For a PC-relative access, the base is first rounded down to the access size. If the instruction sits in a branch delay slot, the base is the address of the jump instead of the slot's own address. An address that is not aligned to the access size is reported as misaligned, and no memory request is made.

Top module: `cls_agu_top`

## Requirements
- R1: With `req_base`=0 (register), the request address is `reg_base` plus `req_offset[4:0]` shifted left by `req_size`, where `req_size` is 0 byte, 1 halfword, 2 word or 3 doubleword. `mem_size` carries the same encoding, and `req_offset[7:5]` has no effect.
- R2: With `req_base`=1 (stack), a word access uses all 8 offset bits times 4. Every other size uses `req_offset[4:0]` shifted by `req_size`, added to `sp_value`.
- R3: With `req_base`=2 (PC), the base is `pc_value` with its low `req_size` bits cleared; 2 bits for a word and 3 for a doubleword. The word form takes the 8-bit offset times 4, and the other sizes take the 5-bit offset scaled by size.
- R4: With `req_base`=2 and `in_delay_slot`=1, `jump_pc` replaces `pc_value` as the base before alignment.
- R5: For a load, `load_data` is the returned data narrowed to the access size. It is sign-extended when `req_unsigned`=0 and zero-extended when `req_unsigned`=1. A doubleword is passed through unchanged.
- R6: A store (`req_store`=1) drives `mem_we`=1 and puts `store_data` on `mem_wdata`, or `ra_value` when `req_ra_src`=1. Its `load_data` at `done` is zero.
- R7: An address whose low bits are not a multiple of the access size raises `misaligned` together with `done`, one cycle after acceptance. It issues no memory request and leaves `load_data` at zero.
- R8: Only one access is in flight. `req_ready` stays low from acceptance until the cycle after `done`. While `mem_valid` is high and `mem_ready` is low, the request stays up with a stable address and size.
- R9: The request appears the cycle after acceptance. `done` pulses for exactly one cycle, in the cycle after the `mem_valid`/`mem_ready` handshake, and `load_data` is valid with it.
- R10: During reset, `req_ready`=1 and `mem_valid`, `done` and `misaligned` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request from the decoder |
| req_ready | output | 1 | Unit idle; a request is accepted |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 half, 2 word, 3 double |
| req_unsigned | input | 1 | Zero-extend load data |
| req_base | input | 2 | 0 register, 1 stack, 2 PC |
| req_offset | input | 8 | Raw unsigned offset field |
| req_ra_src | input | 1 | Store data taken from return-address value |
| reg_base | input | 64 | Base register value |
| sp_value | input | 64 | Stack pointer |
| pc_value | input | 64 | Address of this instruction |
| in_delay_slot | input | 1 | Instruction is in a delay slot |
| jump_pc | input | 64 | Address of the preceding jump |
| store_data | input | 64 | Register store data |
| ra_value | input | 64 | Return-address register value |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts/completes request |
| mem_addr | output | 64 | Request address |
| mem_size | output | 2 | Request size, same encoding as req_size |
| mem_we | output | 1 | Write enable |
| mem_wdata | output | 64 | Write data, right-justified |
| mem_rdata | input | 64 | Read data, right-justified, valid with mem_ready |
| done | output | 1 | Access complete pulse |
| misaligned | output | 1 | Alignment fault, with done |
| load_data | output | 64 | Extended load result |

## Verification
Every cycle, the checker confirms that a pending request holds steady until the memory takes it. It also checks that `done` follows each handshake and never lasts two cycles. It further checks that no request ever leaves with a misaligned address, that a faulting acceptance raises `misaligned` without a request, and that the unit never accepts work while a request is pending. Only the bench scenarios can show the address arithmetic itself. That covers offset width and scaling per base, PC rounding and the delay-slot substitution. The scenarios also cover the choice of store data and the extension of load data, since these depend on values that are compared against a model computed independently in the bench.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  parameter int unsigned LSU_XLEN = 64;
  localparam int unsigned LONG_OFF_W  = 8;
  localparam int unsigned SHORT_OFF_W = 5;

  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD, SZ_DWORD} acc_size_e;
  typedef enum logic [1:0] {BS_REG, BS_STACK, BS_PC, BS_RSVD} base_sel_e;
  typedef enum logic [1:0] {ST_IDLE, ST_MEM, ST_DONE} agu_state_e;

  // Word accesses off the stack or PC carry the wide offset field
  function automatic logic uses_long_off(acc_size_e sz, base_sel_e bs);
    return (sz == SZ_WORD) && ((bs == BS_STACK) || (bs == BS_PC));
  endfunction

  function automatic logic [LSU_XLEN-1:0] low_mask(acc_size_e sz);
    logic [LSU_XLEN-1:0] m;
    m = '0;
    case (sz)
      SZ_HALF:  m[0]   = 1'b1;
      SZ_WORD:  m[1:0] = 2'b11;
      SZ_DWORD: m[2:0] = 3'b111;
      default:  m      = '0;
    endcase
    return m;
  endfunction

  function automatic logic [LSU_XLEN-1:0] scaled_off(acc_size_e sz, logic is_long,
                                                     logic [LONG_OFF_W-1:0] raw);
    logic [LSU_XLEN-1:0] v;
    v = '0;
    if (is_long) v[LONG_OFF_W-1:0] = raw;
    else         v[SHORT_OFF_W-1:0] = raw[SHORT_OFF_W-1:0];
    return v << sz;
  endfunction

  function automatic logic [LSU_XLEN-1:0] extend_load(logic [LSU_XLEN-1:0] d,
                                                      acc_size_e sz, logic uns);
    logic [LSU_XLEN-1:0] r;
    case (sz)
      SZ_BYTE: r = {{(LSU_XLEN-8){~uns & d[7]}}, d[7:0]};
      SZ_HALF: r = {{(LSU_XLEN-16){~uns & d[15]}}, d[15:0]};
      SZ_WORD: r = {{(LSU_XLEN-32){~uns & d[31]}}, d[31:0]};
      default: r = d;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cls_agu_addr.sv
module cls_agu_addr
  import lsu_pkg::*;
#(
  parameter int unsigned XLEN = LSU_XLEN
) (
  input  acc_size_e                size_i,
  input  base_sel_e                base_i,
  input  logic [LONG_OFF_W-1:0]    off_i,
  input  logic [XLEN-1:0]          reg_base_i,
  input  logic [XLEN-1:0]          sp_i,
  input  logic [XLEN-1:0]          pc_i,
  input  logic [XLEN-1:0]          jump_pc_i,
  input  logic                     dslot_i,
  output logic [XLEN-1:0]          addr_o,
  output logic                     misal_o
);
  logic [XLEN-1:0] mask;
  logic [XLEN-1:0] pc_src;
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;

  always_comb begin
    mask   = low_mask(size_i);
    pc_src = dslot_i ? jump_pc_i : pc_i;
    case (base_i)
      BS_STACK: base = sp_i;
      BS_PC:    base = pc_src & ~mask;
      default:  base = reg_base_i;
    endcase
    offset  = scaled_off(size_i, uses_long_off(size_i, base_i), off_i);
    addr_o  = base + offset;
    misal_o = |(addr_o & mask);
  end
endmodule

// File: rtl/cls_agu_ctrl.sv
module cls_agu_ctrl
  import lsu_pkg::*;
#(
  parameter int unsigned XLEN = LSU_XLEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [XLEN-1:0] addr_i,
  input  logic            fault_i,
  input  acc_size_e       size_i,
  input  logic            we_i,
  input  logic            uns_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic [XLEN-1:0] mem_addr,
  output acc_size_e       mem_size,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_wdata,
  output logic            uns_q,
  input  logic [XLEN-1:0] ext_data_i,
  output logic            done,
  output logic            misaligned,
  output logic [XLEN-1:0] load_data,
  output logic            accept_evt,
  output logic            hs_evt
);
  agu_state_e      state;
  logic            fault_q;
  logic [XLEN-1:0] data_q;

  assign accept_evt = req_valid && (state == ST_IDLE);
  assign hs_evt     = (state == ST_MEM) && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      fault_q   <= 1'b0;
      data_q    <= '0;
      mem_addr  <= '0;
      mem_size  <= SZ_BYTE;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
      uns_q     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          mem_addr  <= addr_i;
          mem_size  <= size_i;
          mem_we    <= we_i;
          mem_wdata <= wdata_i;
          uns_q     <= uns_i;
          fault_q   <= fault_i;
          data_q    <= '0;
          state     <= fault_i ? ST_DONE : ST_MEM;
        end
        ST_MEM: if (mem_ready) begin
          data_q <= mem_we ? '0 : ext_data_i;
          state  <= ST_DONE;
        end
        default: begin
          fault_q <= 1'b0;
          state   <= ST_IDLE;
        end
      endcase
    end
  end

  assign req_ready  = (state == ST_IDLE);
  assign mem_valid  = (state == ST_MEM);
  assign done       = (state == ST_DONE);
  assign misaligned = done && fault_q;
  assign load_data  = data_q;
endmodule

// File: rtl/cls_agu_ext.sv
module cls_agu_ext
  import lsu_pkg::*;
#(
  parameter int unsigned XLEN = LSU_XLEN
) (
  input  logic [XLEN-1:0] raw_i,
  input  acc_size_e       size_i,
  input  logic            uns_i,
  output logic [XLEN-1:0] ext_o
);
  assign ext_o = extend_load(raw_i, size_i, uns_i);
endmodule

// File: rtl/cls_agu_top.sv
module cls_agu_top
  import lsu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_store,
  input  logic [1:0]          req_size,
  input  logic                req_unsigned,
  input  logic [1:0]          req_base,
  input  logic [7:0]          req_offset,
  input  logic                req_ra_src,
  input  logic [LSU_XLEN-1:0] reg_base,
  input  logic [LSU_XLEN-1:0] sp_value,
  input  logic [LSU_XLEN-1:0] pc_value,
  input  logic                in_delay_slot,
  input  logic [LSU_XLEN-1:0] jump_pc,
  input  logic [LSU_XLEN-1:0] store_data,
  input  logic [LSU_XLEN-1:0] ra_value,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic [LSU_XLEN-1:0] mem_addr,
  output logic [1:0]          mem_size,
  output logic                mem_we,
  output logic [LSU_XLEN-1:0] mem_wdata,
  input  logic [LSU_XLEN-1:0] mem_rdata,
  output logic                done,
  output logic                misaligned,
  output logic [LSU_XLEN-1:0] load_data
);
  localparam int unsigned XLEN = LSU_XLEN;

  logic [XLEN-1:0] eff_addr;
  logic            addr_fault;
  logic [XLEN-1:0] wdata_sel;
  logic [XLEN-1:0] ext_data;
  logic            uns_q;
  acc_size_e       mem_size_e;
  logic            accept_evt;
  logic            hs_evt;

  assign wdata_sel = req_ra_src ? ra_value : store_data;
  assign mem_size  = mem_size_e;

  cls_agu_addr #(.XLEN(XLEN)) addr_i (
    .size_i     (acc_size_e'(req_size)),
    .base_i     (base_sel_e'(req_base)),
    .off_i      (req_offset),
    .reg_base_i (reg_base),
    .sp_i       (sp_value),
    .pc_i       (pc_value),
    .jump_pc_i  (jump_pc),
    .dslot_i    (in_delay_slot),
    .addr_o     (eff_addr),
    .misal_o    (addr_fault)
  );

  cls_agu_ctrl #(.XLEN(XLEN)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .addr_i     (eff_addr),
    .fault_i    (addr_fault),
    .size_i     (acc_size_e'(req_size)),
    .we_i       (req_store),
    .uns_i      (req_unsigned),
    .wdata_i    (wdata_sel),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_size   (mem_size_e),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata),
    .uns_q      (uns_q),
    .ext_data_i (ext_data),
    .done       (done),
    .misaligned (misaligned),
    .load_data  (load_data),
    .accept_evt (accept_evt),
    .hs_evt     (hs_evt)
  );

  cls_agu_ext #(.XLEN(XLEN)) ext_i (
    .raw_i  (mem_rdata),
    .size_i (mem_size_e),
    .uns_i  (uns_q),
    .ext_o  (ext_data)
  );
endmodule

// File: rtl/cls_agu_chk.sv
module cls_agu_chk
  import lsu_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                req_ready,
  input logic                mem_valid,
  input logic                mem_ready,
  input logic [LSU_XLEN-1:0] mem_addr,
  input logic [1:0]          mem_size,
  input logic                done,
  input logic                misaligned,
  input logic                accept_evt,
  input logic                addr_fault
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_size))); // R8
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready); // R8
  AST_DONE_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (done && !misaligned)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_ALIGNED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> ((mem_addr & ((64'd1 << mem_size) - 64'd1)) == 64'd0)); // R7
  AST_FAULT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && addr_fault) |=> (misaligned && done && !mem_valid)); // R7
  AST_REQ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && !addr_fault) |=> (mem_valid && !done)); // R9
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (req_ready && !mem_valid && !done && !misaligned)); // R10
endmodule

bind cls_agu_top cls_agu_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .mem_size   (mem_size),
  .done       (done),
  .misaligned (misaligned),
  .accept_evt (accept_evt),
  .addr_fault (addr_fault)
);

// File: tb/cls_agu_top_tb_top.sv
module cls_agu_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0, req_ra_src = 1'b0;
  logic [1:0]  req_size = '0, req_base = '0;
  logic [7:0]  req_offset = '0;
  logic [63:0] reg_base = '0, sp_value = '0, pc_value = '0, jump_pc = '0;
  logic [63:0] store_data = '0, ra_value = '0, mem_rdata = '0;
  logic        in_delay_slot = 1'b0, mem_ready = 1'b0;
  logic        req_ready, mem_valid, mem_we, done, misaligned;
  logic [63:0] mem_addr, mem_wdata, load_data;
  logic [1:0]  mem_size;
  int          n_tests = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  cls_agu_top dut_i (.*);

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] e_addr(input logic [1:0] sel, input logic [1:0] sz,
      input logic [7:0] raw, input logic [63:0] rb, input logic [63:0] sp,
      input logic [63:0] pc, input logic [63:0] jpc, input bit ds);
    logic [63:0] nb, off, b;
    nb = 64'd1 << sz;
    if ((sel == 2'd1 || sel == 2'd2) && sz == 2'd2) off = 64'(raw) * 4;
    else off = 64'(raw % 32) * nb;
    if (sel == 2'd1) b = sp;
    else if (sel == 2'd2) begin
      b = ds ? jpc : pc;
      b = b - (b % nb);
    end else b = rb;
    return b + off;
  endfunction

  function automatic logic [63:0] e_ext(input logic [63:0] d, input logic [1:0] sz, input bit uns);
    logic [63:0] keep;
    logic [63:0] v;
    if (sz == 2'd3) return d;
    keep = (64'd1 << (8 << sz)) - 1;
    v = d & keep;
    if (!uns && ((v >> ((8 << sz) - 1)) & 64'd1) == 64'd1) v = v | ~keep;
    return v;
  endfunction

  task automatic run_op(input bit st, input logic [1:0] sz, input bit uns, input logic [1:0] sel,
      input logic [7:0] off, input logic [63:0] rb, input logic [63:0] sp, input logic [63:0] pc,
      input logic [63:0] jpc, input bit ds, input bit rasrc, input logic [63:0] sd,
      input logic [63:0] ra, input logic [63:0] rd);
    logic [63:0] ea, exp_ld;
    bit mis;
    string tag;
    ea  = e_addr(sel, sz, off, rb, sp, pc, jpc, ds);
    mis = (ea % (64'd1 << sz)) != 0;
    tag = (sel == 2'd1) ? "R2" : (sel == 2'd2) ? (ds ? "R4" : "R3") : "R1";
    @(negedge clk);
    req_store = st; req_size = sz; req_unsigned = uns; req_base = sel; req_offset = off;
    reg_base = rb; sp_value = sp; pc_value = pc; jump_pc = jpc; in_delay_slot = ds;
    req_ra_src = rasrc; store_data = sd; ra_value = ra; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (mis) begin
      chk(done && misaligned && !mem_valid, "R7 fault flag", {61'd0, done, misaligned, mem_valid}, 64'd6);
      chk(load_data == 64'd0, "R7 load data", load_data, 64'd0);
    end else begin
      chk(mem_valid && !done && !req_ready, "R9 request issued", {62'd0, mem_valid, done}, 64'd2);
      chk(mem_addr == ea, tag, mem_addr, ea);
      chk(mem_size == sz, "R1 size code", 64'(mem_size), 64'(sz));
      chk(mem_we == st, "R6 write enable", 64'(mem_we), 64'(st));
      if (st) chk(mem_wdata == (rasrc ? ra : sd), "R6 store data", mem_wdata, rasrc ? ra : sd);
      repeat ($urandom % 3) begin
        @(negedge clk);
        chk(mem_valid && !done && !req_ready && mem_addr == ea, "R8 held request", mem_addr, ea);
      end
      mem_ready = 1'b1; mem_rdata = rd;
      @(negedge clk);
      mem_ready = 1'b0; mem_rdata = {$urandom, $urandom};
      chk(done && !misaligned && !mem_valid, "R9 done after handshake",
          {61'd0, done, misaligned, mem_valid}, 64'd4);
      exp_ld = st ? 64'd0 : e_ext(rd, sz, uns);
      chk(load_data == exp_ld, st ? "R6 zero result" : "R5 extension", load_data, exp_ld);
    end
    @(negedge clk);
    chk(!done && req_ready, "R8 ready again", {62'd0, done, req_ready}, 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog actual=%h expected=%h", 64'd1, 64'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_valid && !done && !misaligned, "R10 reset state",
        {60'd0, req_ready, mem_valid, done, misaligned}, 64'd8);
    rst_n = 1'b1;
    // R1: offset bits above the short field ignored
    run_op(0, 2'd0, 0, 2'd0, 8'hE3, 64'h1000, 0, 0, 0, 0, 0, 0, 0, 64'h80);
    run_op(0, 2'd3, 0, 2'd0, 8'h1F, 64'h2000, 0, 0, 0, 0, 0, 0, 0, 64'h8877665544332211);
    // R2: wide word offset and doubleword short offset
    run_op(0, 2'd2, 0, 2'd1, 8'hFF, 0, 64'h8000, 0, 0, 0, 0, 0, 0, 64'h8000_0000);
    run_op(1, 2'd3, 0, 2'd1, 8'hFF, 0, 64'h8000, 0, 0, 0, 0, 64'h55, 0, 0);
    // R3: PC rounded down per size
    run_op(0, 2'd2, 1, 2'd2, 8'hFF, 0, 0, 64'h1002, 0, 0, 0, 0, 0, 64'hF000_0001);
    run_op(0, 2'd3, 0, 2'd2, 8'h01, 0, 0, 64'h1006, 64'h3000, 0, 0, 0, 0, 64'h1);
    // R4: delay slot takes the jump address
    run_op(0, 2'd3, 0, 2'd2, 8'h02, 0, 0, 64'h1006, 64'h300E, 1, 0, 0, 0, 64'h2);
    run_op(0, 2'd2, 0, 2'd2, 8'h10, 0, 0, 64'h1006, 64'h4002, 1, 0, 0, 0, 64'h3);
    // R5: extension corners
    run_op(0, 2'd0, 0, 2'd0, 8'h01, 64'h10, 0, 0, 0, 0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FF80);
    run_op(0, 2'd1, 1, 2'd0, 8'h01, 64'h10, 0, 0, 0, 0, 0, 0, 0, 64'h1234_5678_9ABC_8001);
    run_op(0, 2'd2, 0, 2'd0, 8'h01, 64'h10, 0, 0, 0, 0, 0, 0, 0, 64'h0000_0000_8000_0000);
    // R6: return-address store off the stack
    run_op(1, 2'd2, 0, 2'd1, 8'h04, 0, 64'h9000, 0, 0, 0, 1, 64'h1111, 64'hCAFE_F00D, 0);
    // R7: misaligned halfword and word
    run_op(0, 2'd1, 0, 2'd0, 8'h02, 64'h1001, 0, 0, 0, 0, 0, 0, 0, 0);
    run_op(1, 2'd2, 0, 2'd1, 8'h01, 0, 64'h8002, 0, 0, 0, 0, 64'h9, 0, 0);
    for (int i = 0; i < 400; i++) begin
      logic [63:0] rb, sp;
      rb = {$urandom, $urandom};
      sp = {$urandom, $urandom};
      if ($urandom % 4 != 0) rb[2:0] = 3'd0;
      if ($urandom % 4 != 0) sp[2:0] = 3'd0;
      run_op(1'($urandom), 2'($urandom), 1'($urandom), 2'($urandom % 3), 8'($urandom),
             rb, sp, {$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), 1'($urandom),
             {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule